// File: doc/BRIEF.md
# Receive Frame Gate with Check-Field Strip Delay

This block sits between a serial receive front end and a receive byte FIFO. Software arms it once per frame. The armed gate waits for a begin-of-frame strobe and then assembles incoming bits into bytes, most significant bit first. It compares the first byte, the station address, against a programmable address and mask. Frames that pass are loaded into the FIFO, starting with the address byte.

The bytes go through a shift register whose depth is the frame check length plus one byte: 40 bits for a 32-bit check and 24 bits for a 16-bit check. Because of this, the trailing check bytes are still inside the register when the frame ends, so they never reach the FIFO. Stray bits that do not fill a whole byte are also dropped.

The gate treats a frame in one of two ways, depending on whether any byte has reached the FIFO yet.
- If no byte has reached the FIFO when the frame ends or a collision occurs, the frame is dropped with no flag, and the gate goes back to waiting for a new frame.
- Once a byte has reached the FIFO, a normal end of frame raises a done flag, and a collision raises an abort flag. In both cases the gate disarms itself.

Top module: `rx_frame_gate`

## Requirements
- R1: After reset, `rx_en`, `done`, `abort`, `overrun` and `fifo_we` are all 0.
- R2: While disarmed, all stimulus is ignored and no FIFO write occurs. A one-cycle `arm` pulse sets `rx_en` and clears `done`, `abort` and `overrun`.
- R3: When armed, the gate ignores bits until a `sof` strobe has been seen. Bits received before that strobe produce no FIFO write.
- R4: The first 8 bits after `sof` form the address byte. The frame is accepted when the address equals `match_addr` in every bit position where `match_mask` is 0; a 1 in `match_mask` marks a don't-care bit. The address 8'hFF is always accepted. A rejected frame produces no write, and the gate keeps `rx_en` at 1 and waits for the next `sof`.
- R5: Bits are assembled most significant bit first. The accepted frame's bytes, starting with the address byte, go to the FIFO in order. The first write (`fifo_we` high) appears in the cycle after the 40th bit following `sof` is accepted when `crc_long`=1, or after the 24th bit when `crc_long`=0. Each later write follows 8 bits after the previous one. The last 4 bytes (32-bit check) or 2 bytes (16-bit check) are never written.
- R6: If `eof` arrives before any write slot has occurred, the frame is dropped: `done` stays 0 and `rx_en` stays 1.
- R7: If `eof` arrives after at least one write slot, `done` becomes 1 and `rx_en` becomes 0 on the next cycle.
- R8: If `coll` arrives after at least one write slot, `abort` becomes 1 and `rx_en` becomes 0. If it arrives before any write slot, there is no flag and `rx_en` stays 1. A collision in the same cycle as a bit cancels that bit.
- R9: At a write slot with `fifo_full`=1, the byte is dropped, `fifo_we` stays 0 and `overrun` becomes 1. The slot still counts as a write for R6 to R8.
- R10: The check length is taken from `crc_long` at `sof`. Later changes to `crc_long` do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Pulse: enable reception and clear status flags |
| crc_long | input | 1 | 1 selects a 32-bit check field, 0 selects 16-bit |
| match_addr | input | 8 | Station address to compare |
| match_mask | input | 8 | 1 marks a don't-care address bit |
| sof | input | 1 | Begin-of-frame strobe |
| eof | input | 1 | End-of-frame strobe |
| bit_vld | input | 1 | `bit_in` is valid this cycle |
| bit_in | input | 1 | Serial receive data |
| coll | input | 1 | Collision seen on the line |
| fifo_full | input | 1 | Receive FIFO cannot accept a byte |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write byte |
| rx_en | output | 1 | Receiver armed |
| done | output | 1 | Frame completed normally (sticky) |
| abort | output | 1 | Frame aborted by collision (sticky) |
| overrun | output | 1 | A byte was dropped because the FIFO was full (sticky) |

## Verification
A collision can fall in the same cycle as the bit that would open the first write slot. The bench provokes this by sending 39 bits after `sof` and then raising `coll` and `bit_vld` together. The expected result is that the collision wins: no byte is written, `abort` stays 0 and `rx_en` stays 1. A second coincidence is a write slot that falls while `fifo_full` is high. There, the overrun flag and the slot accounting must both update, so that the following `eof` still sets `done`.

// File: rtl/rx_frame_gate.sv
module rx_frame_gate #(
  parameter int AW = 8,
  parameter int CRC_L = 32,
  parameter int CRC_S = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          crc_long,
  input  logic [AW-1:0] match_addr,
  input  logic [AW-1:0] match_mask,
  input  logic          sof,
  input  logic          eof,
  input  logic          bit_vld,
  input  logic          bit_in,
  input  logic          coll,
  input  logic          fifo_full,
  output logic          fifo_we,
  output logic [AW-1:0] fifo_wdata,
  output logic          rx_en,
  output logic          done,
  output logic          abort,
  output logic          overrun
);
  localparam int DL = CRC_L + AW;
  localparam int DS = CRC_S + AW;
  localparam int CW = $clog2(DL / AW) + 1;
  localparam int BW = $clog2(AW);

  typedef enum logic [1:0] {OFF, HUNT, ADDR, DATA} st_t;
  st_t st;

  logic [DL-1:0] sr;
  logic [BW-1:0] bcnt;
  logic [CW-1:0] nby;
  logic          long_q, wrote;

  wire [DL-1:0] sr_nx    = {sr[DL-2:0], bit_in};
  wire [AW-1:0] addr_nx  = sr_nx[AW-1:0];
  wire          byte_end = bit_vld && (bcnt == BW'(AW - 1));
  wire          addr_ok  = (((addr_nx ^ match_addr) & ~match_mask) == '0) || (&addr_nx);
  wire [CW-1:0] need     = long_q ? CW'(DL / AW - 1) : CW'(DS / AW - 1);
  wire [AW-1:0] out_byte = long_q ? sr_nx[DL-1 -: AW] : sr_nx[DS-1 -: AW];

  assign rx_en = (st != OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= OFF; sr <= '0; bcnt <= '0; nby <= '0; long_q <= 1'b0; wrote <= 1'b0;
      fifo_we <= 1'b0; fifo_wdata <= '0; done <= 1'b0; abort <= 1'b0; overrun <= 1'b0;
    end else begin
      fifo_we <= 1'b0;
      if (arm) begin
        done <= 1'b0; abort <= 1'b0; overrun <= 1'b0;
      end
      case (st)
        OFF:  if (arm) st <= HUNT;
        HUNT: if (sof) begin
          st <= ADDR; long_q <= crc_long; bcnt <= '0; nby <= '0; wrote <= 1'b0;
        end
        default: begin
          if (coll) begin
            if (wrote) begin abort <= 1'b1; st <= OFF; end
            else st <= HUNT;
          end else if (eof) begin
            if (wrote) begin done <= 1'b1; st <= OFF; end
            else st <= HUNT;
          end else if (bit_vld) begin
            sr   <= sr_nx;
            bcnt <= bcnt + 1'b1;
            if (byte_end) begin
              if (st == ADDR) begin
                if (addr_ok) begin st <= DATA; nby <= CW'(1); end
                else st <= HUNT;
              end else if (nby != need) begin
                nby <= nby + 1'b1;
              end else begin
                wrote <= 1'b1;
                if (fifo_full) overrun <= 1'b1;
                else begin fifo_we <= 1'b1; fifo_wdata <= out_byte; end
              end
            end
          end
        end
      endcase
    end
  end

  // R2: a write only ever follows an armed cycle
  a_r2_write_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> $past(rx_en));
  // R9: no write is issued into a full FIFO
  a_r9_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> $past(!fifo_full));
  // R7: completion disarms the receiver
  a_r7_done_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !rx_en);
  // R8: abort disarms the receiver
  a_r8_abort_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort) |-> !rx_en);
  // R8: one frame cannot both complete and abort
  a_r8_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(done) && $rose(abort)));
endmodule

// File: tb/rx_frame_gate_tb.sv
`timescale 1ns/1ps
module rx_frame_gate_tb;
  logic clk = 0, rst_n = 0;
  logic arm = 0, crc_long = 1, sof = 0, eof = 0, bit_vld = 0, bit_in = 0, coll = 0, fifo_full = 0;
  logic [7:0] match_addr = 8'h5A, match_mask = 8'h00;
  logic fifo_we, rx_en, done, abort, overrun;
  logic [7:0] fifo_wdata;

  int checks = 0, fails = 0;
  logic [7:0] expq[$];
  logic [7:0] fb[16];

  always #4 clk = ~clk;

  rx_frame_gate u_dut (.clk, .rst_n, .arm, .crc_long, .match_addr, .match_mask,
    .sof, .eof, .bit_vld, .bit_in, .coll, .fifo_full, .fifo_we, .fifo_wdata,
    .rx_en, .done, .abort, .overrun);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard: R5 byte order and content
  always @(negedge clk) if (rst_n && fifo_we) begin
    if (expq.size() == 0) chk(0, "R5 unexpected write", fifo_wdata, 0);
    else begin
      logic [7:0] e;
      e = expq.pop_front();
      chk(fifo_wdata == e, "R5 byte", fifo_wdata, e);
    end
  end

  task automatic cyc(); @(negedge clk); endtask
  task automatic send_bit(input logic b);
    bit_in = b; bit_vld = 1; cyc(); bit_vld = 0;
  endtask
  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask
  task automatic do_arm(); arm = 1; cyc(); arm = 0; endtask
  task automatic do_sof(input logic lng); crc_long = lng; sof = 1; cyc(); sof = 0; endtask
  task automatic do_eof(); eof = 1; cyc(); eof = 0; endtask

  // driver: sends fb[0..n-1], pushes expected bytes when the frame should be accepted
  task automatic frame(input logic lng, input int n, input logic accept);
    int cb;
    cb = lng ? 4 : 2;
    if (accept) for (int i = 0; i < n - cb; i++) expq.push_back(fb[i]);
    do_sof(lng);
    for (int i = 0; i < n; i++) send_byte(fb[i]);
    do_eof();
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    chk(!rx_en && !done && !abort && !overrun && !fifo_we, "R1 reset state",
        {rx_en, done, abort, overrun, fifo_we}, 0);
    rst_n = 1; cyc();

    // R2: disarmed, frame ignored
    fb[0] = 8'h5A; fb[1] = 8'h01; fb[2] = 8'h02; fb[3] = 8'h03; fb[4] = 8'h04; fb[5] = 8'h05;
    frame(1, 6, 0);
    chk(!rx_en && !done, "R2 disarmed ignores", {rx_en, done}, 0);
    do_arm();
    chk(rx_en, "R2 arm sets enable", rx_en, 1);

    // R3: bits before sof ignored, then a 32-bit-check frame
    for (int i = 0; i < 16; i++) send_bit(i[0]);
    fb[0] = 8'h5A; fb[1] = 8'h11; fb[2] = 8'h22; fb[3] = 8'h33;
    fb[4] = 8'hC1; fb[5] = 8'hC2; fb[6] = 8'hC3; fb[7] = 8'hC4;
    frame(1, 8, 1);
    chk(done && !rx_en, "R7 done after frame", {done, rx_en}, 2);
    chk(expq.size() == 0, "R3 R5 all bytes written", expq.size(), 0);

    // R5 with 16-bit check
    do_arm();
    chk(!done, "R2 arm clears done", done, 0);
    fb[0] = 8'h5A; fb[1] = 8'h44; fb[2] = 8'h55; fb[3] = 8'hD1; fb[4] = 8'hD2;
    frame(0, 5, 1);
    chk(done && expq.size() == 0, "R5 16-bit strip", expq.size(), 0);

    // R4: mismatch, mask, broadcast
    do_arm();
    fb[0] = 8'h5B; frame(1, 6, 0);
    chk(rx_en && !done, "R4 mismatch dropped, enabled", {rx_en, done}, 2);
    match_mask = 8'h0F;
    fb[0] = 8'h53; fb[1] = 8'h9E; frame(0, 4, 1);
    chk(done && expq.size() == 0, "R4 masked match", expq.size(), 0);
    do_arm(); match_mask = 8'h00;
    fb[0] = 8'hFF; fb[1] = 8'hA7; frame(0, 4, 1);
    chk(done && expq.size() == 0, "R4 broadcast", expq.size(), 0);

    // R5 timing: first write exactly after 40th bit
    do_arm();
    expq.push_back(8'h5A);
    do_sof(1);
    send_byte(8'h5A);
    for (int i = 0; i < 31; i++) send_bit(0);
    chk(!fifo_we, "R5 no write at bit 39", fifo_we, 0);
    send_bit(0);
    chk(fifo_we && fifo_wdata == 8'h5A, "R5 write after bit 40", fifo_we, 1);
    // R8: collision after a write
    coll = 1; cyc(); coll = 0;
    chk(abort && !rx_en, "R8 abort after write", {abort, rx_en}, 2);

    // R6: eof before any write
    do_arm();
    fb[0] = 8'h5A; fb[1] = 8'h12; fb[2] = 8'h34; fb[3] = 8'h56;
    frame(1, 4, 0);
    chk(rx_en && !done, "R6 short frame silent", {rx_en, done}, 2);

    // R8: collision before a write
    do_sof(1); send_byte(8'h5A); for (int i = 0; i < 12; i++) send_bit(1);
    coll = 1; cyc(); coll = 0;
    chk(rx_en && !abort, "R8 early collision silent", {rx_en, abort}, 2);

    // R8 corner: collision in the same cycle as the 40th bit
    do_sof(1); send_byte(8'h5A); for (int i = 0; i < 31; i++) send_bit(1);
    coll = 1; bit_in = 1; bit_vld = 1; cyc(); coll = 0; bit_vld = 0;
    chk(!fifo_we && rx_en && !abort, "R8 coll beats slot", {fifo_we, rx_en, abort}, 2);

    // R9: overrun
    fifo_full = 1;
    fb[0] = 8'h5A; fb[1] = 8'h66; fb[2] = 8'hE1; fb[3] = 8'hE2;
    frame(0, 4, 0);
    fifo_full = 0;
    chk(overrun && done && !rx_en, "R9 overrun, slot counted", {overrun, done, rx_en}, 6);

    // R10: check length latched at sof
    do_arm();
    expq.push_back(8'h5A); expq.push_back(8'h77);
    crc_long = 0; sof = 1; cyc(); sof = 0; crc_long = 1;
    send_byte(8'h5A); send_byte(8'h77); send_byte(8'hF1); send_byte(8'hF2);
    do_eof();
    chk(done && expq.size() == 0, "R10 latched check length", expq.size(), 0);

    repeat (2) cyc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule